// File: doc/BRIEF.md
# Windowed Audio Silence Detector

This block sits on the transmit audio path and watches a stream of rectified amplitude samples, each qualified by a valid strobe. When the input stays quiet for a whole observation window, the block mutes the path automatically. It unmutes once enough loud samples arrive.

Entry into the muted state and exit from it use different amplitude levels and different count limits. This gives hysteresis, so the mute does not chatter on a marginal signal. A manual mute bit forces the output muted at any time. A read-only flag reports whether the automatic mute is in force.

All configuration fields are plain inputs that a register block outside this one drives. These fields are:
- a detector disable bit;
- a window code;
- low and high threshold codes;
- low and high count limits.

Top module: `silence_mute`

## Requirements
- R1: After the active-low reset `rst_n` is released, `silence_o` is 0 and `mute_o` equals `manual_mute_i`.
- R2: With the detector enabled, a window lasts exactly 2^(`win_code_i`+8) valid samples. An entry decision is taken only on the last sample of a window, and `silence_o` changes on the clock edge that accepts that sample.
- R3: The low level is 256 shifted left by `lo_thr_code_i` (16-bit compare). A sample counts as loud for the window only when it is strictly greater than that level. If the number of loud samples in a window is smaller than `lo_lim_i`, `silence_o` becomes 1 at the window end.
- R4: A window whose loud-sample count is equal to or larger than `lo_lim_i` leaves `silence_o` at 0. A limit of 0 therefore never enters the muted state.
- R5: While `silence_o` is 1, every valid sample strictly above 256 shifted left by `hi_thr_code_i` is counted. The counting continues across window boundaries. On the sample that makes this count exceed `hi_lim_i`, `silence_o` returns to 0 on that clock edge.
- R6: While `det_dis_i` is 1, `silence_o` is held at 0. Any change of `det_dis_i` restarts the window and clears both counts.
- R7: `mute_o` is 1 whenever `manual_mute_i` is 1 or `silence_o` is 1, and 0 otherwise.
- R8: A cycle with `sample_vld_i` at 0 does not advance the window, does not count, and does not change `silence_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| sample_i | input | 16 | Rectified amplitude sample |
| sample_vld_i | input | 1 | Sample qualifier |
| det_dis_i | input | 1 | 1 disables automatic detection |
| win_code_i | input | 3 | Window length code |
| lo_thr_code_i | input | 3 | Entry amplitude level code |
| hi_thr_code_i | input | 3 | Exit amplitude level code |
| lo_lim_i | input | 3 | Entry count limit |
| hi_lim_i | input | 3 | Exit count limit |
| manual_mute_i | input | 1 | Forced mute |
| mute_o | output | 1 | Combined mute |
| silence_o | output | 1 | Automatic silence state |

## Verification
The hardest cases to reach from the ports are the restart of a partly filled window, and the point at which a window ends. Both need hundreds of samples in an exact count, and the window position cannot be observed directly.

The stimulus always starts from a known window origin by toggling the disable bit. It then feeds exactly one sample fewer than the window length and checks that the flag is still clear. It then feeds the last sample and checks that the flag changes at that point.

The restart case works the same way. The stimulus abandons a window after 100 samples and shows that entry then needs a full fresh window. Idle gaps inside a window show that invalid cycles do not advance it.

// File: rtl/silence_mute.sv
module silence_mute #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 3,
  parameter int LIM_W    = 3,
  parameter int CNT_W    = 4,
  parameter int WIN_BASE = 8,
  parameter int LVL_BASE = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic                det_dis_i,
  input  logic [CODE_W-1:0]   win_code_i,
  input  logic [CODE_W-1:0]   lo_thr_code_i,
  input  logic [CODE_W-1:0]   hi_thr_code_i,
  input  logic [LIM_W-1:0]    lo_lim_i,
  input  logic [LIM_W-1:0]    hi_lim_i,
  input  logic                manual_mute_i,
  output logic                mute_o,
  output logic                silence_o
);
  localparam int WIN_W = WIN_BASE + (1 << CODE_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WIN_W-1:0]    win_cnt, win_last;
  logic [CNT_W-1:0]    lo_cnt, hi_cnt, lo_next, hi_next;
  logic [SAMPLE_W-1:0] lo_lvl, hi_lvl;
  logic                dis_q, silent, lo_hit, hi_hit, win_end, restart;

  assign win_last = {WIN_W{1'b1}} >> (WIN_W - (int'(win_code_i) + WIN_BASE));
  assign lo_lvl   = SAMPLE_W'(LVL_BASE) << lo_thr_code_i;
  assign hi_lvl   = SAMPLE_W'(LVL_BASE) << hi_thr_code_i;
  assign lo_hit   = sample_i > lo_lvl;
  assign hi_hit   = sample_i > hi_lvl;
  assign win_end  = win_cnt == win_last;
  assign restart  = det_dis_i || (det_dis_i != dis_q);

  always_comb begin
    lo_next = lo_cnt;
    if (lo_hit && lo_cnt != CNT_MAX) lo_next = lo_cnt + 1'b1;
    hi_next = hi_cnt;
    if (hi_hit && hi_cnt != CNT_MAX) hi_next = hi_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      silent  <= 1'b0;
      win_cnt <= '0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
    end else begin
      dis_q <= det_dis_i;
      if (restart) begin
        win_cnt <= '0;
        lo_cnt  <= '0;
        hi_cnt  <= '0;
        if (det_dis_i) silent <= 1'b0;
      end else if (sample_vld_i) begin
        win_cnt <= win_end ? '0 : win_cnt + 1'b1;
        lo_cnt  <= win_end ? '0 : lo_next;
        if (silent) begin
          if (hi_next > CNT_W'(hi_lim_i)) begin
            silent <= 1'b0;
            hi_cnt <= '0;
          end else begin
            hi_cnt <= hi_next;
          end
        end else if (win_end && lo_next < CNT_W'(lo_lim_i)) begin
          silent <= 1'b1;
        end
      end
    end
  end

  assign silence_o = silent;
  assign mute_o    = manual_mute_i | silent;
endmodule

// File: rtl/silence_mute_chk.sv
module silence_mute_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] sample_i,
  input logic        sample_vld_i,
  input logic        det_dis_i,
  input logic [2:0]  hi_thr_code_i,
  input logic        manual_mute_i,
  input logic        mute_o,
  input logic        silence_o
);
  logic [15:0] hi_lvl;
  assign hi_lvl = 16'd256 << hi_thr_code_i;

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    det_dis_i |=> !silence_o); // R6
  AST_MANUAL_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    manual_mute_i |-> mute_o); // R7
  AST_QUIET_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mute_i && !silence_o) |-> !mute_o); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld_i && !det_dis_i) |=> $stable(silence_o)); // R8
  AST_ENTRY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(silence_o) |-> ($past(sample_vld_i) && !$past(det_dis_i))); // R2
  AST_EXIT_ON_LOUD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(silence_o) |-> ($past(det_dis_i) ||
      ($past(sample_vld_i) && $past(sample_i) > $past(hi_lvl)))); // R5
endmodule

bind silence_mute silence_mute_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
  .det_dis_i(det_dis_i), .hi_thr_code_i(hi_thr_code_i),
  .manual_mute_i(manual_mute_i), .mute_o(mute_o), .silence_o(silence_o));

// File: tb/silence_mute_tb_top.sv
`timescale 1ns/1ps
module silence_mute_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] sample_i = 0;
  logic sample_vld_i = 0, det_dis_i = 0, manual_mute_i = 0;
  logic [2:0] win_code_i = 0, lo_thr_code_i = 0, hi_thr_code_i = 0, lo_lim_i = 1, hi_lim_i = 0;
  logic mute_o, silence_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  silence_mute dut_i (.*);

  // {lo_code, lo_lim, amplitude, loud count, expected silence}
  localparam logic [30:0] VEC [7] = '{
    {3'd0, 3'd3, 16'd300,   8'd2,  1'b1},
    {3'd0, 3'd3, 16'd300,   8'd3,  1'b0},
    {3'd0, 3'd3, 16'd256,   8'd5,  1'b1},
    {3'd2, 3'd1, 16'd1000,  8'd10, 1'b1},
    {3'd2, 3'd1, 16'd1025,  8'd1,  1'b0},
    {3'd0, 3'd0, 16'd0,     8'd0,  1'b0},
    {3'd7, 3'd1, 16'd40000, 8'd50, 1'b0}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] amp);
    @(negedge clk);
    sample_i = amp;
    sample_vld_i = 1;
    @(posedge clk);
    #1 sample_vld_i = 0;
  endtask

  task automatic send_n(input logic [15:0] amp, input int n);
    for (int i = 0; i < n; i++) send(amp);
  endtask

  task automatic rearm();
    @(negedge clk) det_dis_i = 1;
    @(negedge clk);
    @(negedge clk) det_dis_i = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 silence after reset", silence_o, 1'b0);
    check("R1 mute after reset", mute_o, 1'b0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      rearm();
      lo_thr_code_i = VEC[v][30:28];
      lo_lim_i = VEC[v][27:25];
      send_n(VEC[v][24:9], int'(VEC[v][8:1]));
      send_n(16'd0, 255 - int'(VEC[v][8:1]));
      check("R2 no decision before window end", silence_o, 1'b0);
      send(16'd0);
      check(VEC[v][0] ? "R3 entry at window end" : "R4 no entry at window end",
            silence_o, VEC[v][0]);
    end

    // R7 manual mute and combined output
    rearm();
    lo_thr_code_i = 0; lo_lim_i = 1;
    @(negedge clk) manual_mute_i = 1;
    @(negedge clk);
    check("R7 manual mute alone", mute_o, 1'b1);
    manual_mute_i = 0;
    @(negedge clk);
    check("R7 unmuted", mute_o, 1'b0);

    // R5 exit with hysteresis
    send_n(16'd0, 256);
    check("R3 quiet window enters", silence_o, 1'b1);
    check("R7 mute follows silence", mute_o, 1'b1);
    hi_thr_code_i = 1; hi_lim_i = 2;
    send_n(16'd600, 2);
    send(16'd512);
    check("R5 at limit still silent", silence_o, 1'b1);
    send(16'd600);
    check("R5 exit when count exceeds limit", silence_o, 1'b0);
    check("R7 mute released", mute_o, 1'b0);

    // R6 disable
    rearm();
    send_n(16'd0, 256);
    check("R6 enabled entry", silence_o, 1'b1);
    @(negedge clk) det_dis_i = 1;
    @(negedge clk);
    check("R6 disable clears", silence_o, 1'b0);
    send_n(16'd0, 300);
    check("R6 no entry while disabled", silence_o, 1'b0);
    @(negedge clk) det_dis_i = 0;
    @(negedge clk);

    // R6 restart of a partial window
    send_n(16'd0, 100);
    @(negedge clk) det_dis_i = 1;
    @(negedge clk) det_dis_i = 0;
    @(negedge clk);
    send_n(16'd0, 255);
    check("R6 restarted window not yet over", silence_o, 1'b0);
    send(16'd0);
    check("R6 fresh window ends", silence_o, 1'b1);

    // R8 idle cycles do not advance the window
    rearm();
    send_n(16'd0, 255);
    sample_i = 16'hFFFF;
    repeat (10) @(negedge clk);
    check("R8 idle cycles ignored", silence_o, 1'b0);
    send(16'd0);
    check("R8 window resumes", silence_o, 1'b1);

    // R2 longer window
    rearm();
    win_code_i = 1;
    send_n(16'd0, 511);
    check("R2 code 1 before 512", silence_o, 1'b0);
    send(16'd0);
    check("R2 code 1 at 512", silence_o, 1'b1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule